// File: doc/BRIEF.md
# Raw code to millivolt scaler

This block turns a raw converter result and a channel number into a signed value in millivolts, or milliamps or tenths of a degree, depending on what the channel measures. Three channel groups can be calibrated. Each group has a gain and an offset that the surrounding logic supplies. When a group's gain is nonzero, its channels use the affine calibrated form. When the gain is zero, they fall back to a nominal straight-line map that spreads a fixed minimum-to-maximum range over all 2^CODE_W codes. Channels outside the three groups always use their nominal map. A channel number that names no channel returns an error instead of a value.

Inputs arrive on a valid/ready handshake. Once the block leaves reset, it accepts one item on every cycle. The coefficients are sampled in the same cycle as the item they apply to. Each result appears on a registered output strobe a fixed number of cycles later. There is no output back-pressure.

Top module: `mv_scaler`

## Requirements
- R1: While reset is asserted, out_valid, out_err and in_ready are low. in_ready rises within three rising edges after reset is released and stays high from then on.
- R2: An item accepted on a rising edge (in_valid and in_ready both high) gives exactly one out_valid pulse one cycle wide. The pulse is visible after the third rising edge, counting the accepting edge as the first. Items accepted on consecutive cycles give results on consecutive cycles, in order.
- R3: Channel numbers are: 1 battery control, 2 thermistor ball, 3 main charger voltage, 4 accessory detect one, 5 accessory detect two, 6 auxiliary one, 7 auxiliary two, 8 battery voltage, 9 bus supply voltage, 10 main charger current, 11 USB charger current, 12 backup cell voltage, 13 die temperature. Channel 3 belongs to the main group (gain_main/ofs_main). Channels 1, 2, 4, 6 and 7 belong to the temperature group (gain_temp/ofs_temp). Channel 8 belongs to the battery group (gain_vbat/ofs_vbat).
- R4: For a grouped channel whose group gain is nonzero, out_mv = (code * gain + offset) / 1000, with the offset signed and the quotient truncated toward zero, including for negative sums.
- R5: For a grouped channel whose group gain is zero, out_mv is the nominal value. The nominal ranges are: main group 0..20030, temperature group 0..1350, battery group 2300..4800.
- R6: Channels 5, 9, 10, 11, 12 and 13 always give their nominal value, whatever the gains. Their ranges are: channel 5 0..2500, channel 9 0..20030, channels 10 and 11 0..1500, channel 12 0..3200, channel 13 0..1350.
- R7: The nominal value is min + floor((max - min) * code / 1024).
- R8: Channel numbers 0 and 14..31 give out_err = 1 with out_mv = 0 on their out_valid pulse. For every known channel, out_err = 0.
- R9: Each group's result depends only on that group's gain and offset. A zero gain in one group does not move another group off its calibrated form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Item offered |
| in_ready | output | 1 | Block can take an item |
| in_chan | input | 5 | Channel number |
| in_code | input | CODE_W | Raw converter code |
| gain_main | input | GAIN_W | Main group gain, zero means uncalibrated |
| ofs_main | input | OFS_W | Main group offset, signed |
| gain_temp | input | GAIN_W | Temperature group gain |
| ofs_temp | input | OFS_W | Temperature group offset, signed |
| gain_vbat | input | GAIN_W | Battery group gain |
| ofs_vbat | input | OFS_W | Battery group offset, signed |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Unknown channel, qualified by out_valid |
| out_mv | output | OUT_W | Signed result, zero on error |

## Verification
The bench drives a negative temperature-group offset so that the calibrated sum falls below zero. A divider that rounds toward minus infinity would then return a result one lower than expected. It clears one group's gain while the others stay set. A design that shares a single "calibrated" flag between groups, or maps a channel to the wrong group, would either keep the cleared group on the affine form or push its neighbours onto the nominal line. It also checks the end codes 0 and 1023, the battery channel's nonzero minimum, and the unused numbers 0, 14 and 31. A latency that is off by a cycle, or an error flag that leaks a value, each breaks the comparison made in the scoreboard.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

  localparam int CHAN_W = 5;
  localparam int NOM_W  = 16;

  localparam logic [CHAN_W-1:0] CH_BATCTL  = 5'd1;
  localparam logic [CHAN_W-1:0] CH_TBALL   = 5'd2;
  localparam logic [CHAN_W-1:0] CH_MCHG_V  = 5'd3;
  localparam logic [CHAN_W-1:0] CH_ACC1    = 5'd4;
  localparam logic [CHAN_W-1:0] CH_ACC2    = 5'd5;
  localparam logic [CHAN_W-1:0] CH_AUX1    = 5'd6;
  localparam logic [CHAN_W-1:0] CH_AUX2    = 5'd7;
  localparam logic [CHAN_W-1:0] CH_BAT_V   = 5'd8;
  localparam logic [CHAN_W-1:0] CH_BUS_V   = 5'd9;
  localparam logic [CHAN_W-1:0] CH_MCHG_I  = 5'd10;
  localparam logic [CHAN_W-1:0] CH_UCHG_I  = 5'd11;
  localparam logic [CHAN_W-1:0] CH_BKUP_V  = 5'd12;
  localparam logic [CHAN_W-1:0] CH_DIE_T   = 5'd13;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_MAIN = 2'd1,
    GRP_TEMP = 2'd2,
    GRP_VBAT = 2'd3
  } grp_e;

  typedef struct packed {
    logic             known;
    grp_e             grp;
    logic [NOM_W-1:0] nmin;
    logic [NOM_W-1:0] span;
  } chan_info_t;

endpackage

// File: rtl/mvs_chan_map.sv
module mvs_chan_map
  import mvs_pkg::*;
(
  input  logic [CHAN_W-1:0] chan,
  output chan_info_t        info
);

  function automatic chan_info_t mk(input grp_e g, input int lo, input int hi);
    chan_info_t r;
    r.known = 1'b1;
    r.grp   = g;
    r.nmin  = NOM_W'(lo);
    r.span  = NOM_W'(hi - lo);
    return r;
  endfunction

  always_comb begin
    info = '0;
    unique case (chan)
      CH_MCHG_V: info = mk(GRP_MAIN, 0, 20030);
      CH_BATCTL,
      CH_TBALL,
      CH_ACC1,
      CH_AUX1,
      CH_AUX2:   info = mk(GRP_TEMP, 0, 1350);
      CH_BAT_V:  info = mk(GRP_VBAT, 2300, 4800);
      CH_DIE_T:  info = mk(GRP_NONE, 0, 1350);
      CH_ACC2:   info = mk(GRP_NONE, 0, 2500);
      CH_BUS_V:  info = mk(GRP_NONE, 0, 20030);
      CH_MCHG_I,
      CH_UCHG_I: info = mk(GRP_NONE, 0, 1500);
      CH_BKUP_V: info = mk(GRP_NONE, 0, 3200);
      default:   info = '0;
    endcase
  end

endmodule

// File: rtl/mvs_mac.sv
module mvs_mac #(
  parameter int CODE_W = 10,
  parameter int COEF_W = 20,
  parameter int BIAS_W = 33,
  parameter int ACC_W  = 34
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [CODE_W-1:0]        code,
  input  logic [COEF_W-1:0]        coef,
  input  logic signed [BIAS_W-1:0] bias,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int PROD_W = CODE_W + COEF_W;

  logic [PROD_W-1:0]       prod;
  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    prod  = PROD_W'(code) * PROD_W'(coef);
    acc_d = $signed(ACC_W'(prod)) + ACC_W'(bias);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc_d;
  end

endmodule

// File: rtl/mvs_div_const.sv
module mvs_div_const #(
  parameter int IN_W = 34,
  parameter int DIV  = 1000
) (
  input  logic signed [IN_W-1:0] num,
  output logic signed [IN_W-1:0] quo
);

  localparam int DLOG = $clog2(DIV);

  logic            neg;
  logic [IN_W-1:0] mag;
  logic [IN_W-1:0] qmag;

  always_comb begin
    neg = num[IN_W-1];
    mag = neg ? IN_W'(-num) : IN_W'(num);
  end

  generate
    if ((1 << DLOG) == DIV) begin : g_pow2
      always_comb qmag = mag >> DLOG;
    end else begin : g_recip
      localparam int SH      = IN_W + DLOG;
      localparam int RECIP_W = IN_W + 2;
      localparam int PROD_W  = IN_W + RECIP_W;
      localparam logic [63:0] RECIP64 =
        ((64'd1 << SH) + 64'(DIV) - 64'd1) / 64'(DIV);
      logic [PROD_W-1:0] prod;
      always_comb begin
        prod = PROD_W'(mag) * PROD_W'(RECIP_W'(RECIP64));
        qmag = IN_W'(prod >> SH);
      end
    end
  endgenerate

  always_comb quo = neg ? -$signed(qmag) : $signed(qmag);

endmodule

// File: rtl/mv_scaler.sv
module mv_scaler
  import mvs_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int GAIN_W  = 20,
  parameter int OFS_W   = 32,
  parameter int OUT_W   = 32,
  parameter int CAL_DIV = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [4:0]              in_chan,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [GAIN_W-1:0]       gain_main,
  input  logic signed [OFS_W-1:0] ofs_main,
  input  logic [GAIN_W-1:0]       gain_temp,
  input  logic signed [OFS_W-1:0] ofs_temp,
  input  logic [GAIN_W-1:0]       gain_vbat,
  input  logic signed [OFS_W-1:0] ofs_vbat,
  output logic                    out_valid,
  output logic                    out_err,
  output logic signed [OUT_W-1:0] out_mv
);

  localparam int NOMB_W = NOM_W + CODE_W;
  localparam int BIAS_W = ((OFS_W > NOMB_W) ? OFS_W : NOMB_W) + 1;
  localparam int PROD_W = CODE_W + GAIN_W + 1;
  localparam int ACC_W  = ((BIAS_W > PROD_W) ? BIAS_W : PROD_W) + 1;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign in_ready = rst_sync_n;

  // stage A: decode, group select, calibrated / nominal choice
  chan_info_t info;
  mvs_chan_map u_map (.chan(in_chan), .info(info));

  logic                     acc_en;
  logic [GAIN_W-1:0]        sel_gain;
  logic signed [OFS_W-1:0]  sel_ofs;
  logic                     use_cal;
  logic [GAIN_W-1:0]        a_coef_d;
  logic signed [BIAS_W-1:0] a_bias_d;

  always_comb begin
    acc_en = in_valid & in_ready;
    unique case (info.grp)
      GRP_MAIN: begin sel_gain = gain_main; sel_ofs = ofs_main; end
      GRP_TEMP: begin sel_gain = gain_temp; sel_ofs = ofs_temp; end
      GRP_VBAT: begin sel_gain = gain_vbat; sel_ofs = ofs_vbat; end
      default:  begin sel_gain = '0;        sel_ofs = '0;       end
    endcase
    use_cal  = (info.grp != GRP_NONE) && (sel_gain != '0);
    a_coef_d = use_cal ? sel_gain : GAIN_W'(info.span);
    a_bias_d = use_cal ? BIAS_W'(sel_ofs)
                       : $signed(BIAS_W'({info.nmin, {CODE_W{1'b0}}}));
  end

  logic                     a_vld, a_err, a_cal;
  logic [CODE_W-1:0]        a_code;
  logic [GAIN_W-1:0]        a_coef;
  logic signed [BIAS_W-1:0] a_bias;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_vld <= 1'b0;
    end else begin
      a_vld <= acc_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_err  <= 1'b0;
      a_cal  <= 1'b0;
      a_code <= '0;
      a_coef <= '0;
      a_bias <= '0;
    end else if (acc_en) begin
      a_err  <= ~info.known;
      a_cal  <= use_cal;
      a_code <= in_code;
      a_coef <= a_coef_d;
      a_bias <= a_bias_d;
    end
  end

  // stage B: multiply-accumulate
  logic                    b_vld, b_err, b_cal;
  logic signed [ACC_W-1:0] b_acc;

  mvs_mac #(
    .CODE_W(CODE_W), .COEF_W(GAIN_W), .BIAS_W(BIAS_W), .ACC_W(ACC_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_sync_n), .en(a_vld),
    .code(a_code), .coef(a_coef), .bias(a_bias), .acc(b_acc)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      b_vld <= 1'b0;
      b_err <= 1'b0;
      b_cal <= 1'b0;
    end else begin
      b_vld <= a_vld;
      if (a_vld) begin
        b_err <= a_err;
        b_cal <= a_cal;
      end
    end
  end

  // stage C: scale down and register the result
  logic signed [ACC_W-1:0] c_cal, c_nom, c_val;
  logic signed [OUT_W-1:0] out_mv_d;

  mvs_div_const #(.IN_W(ACC_W), .DIV(CAL_DIV)) u_div (.num(b_acc), .quo(c_cal));

  always_comb begin
    c_nom    = b_acc >>> CODE_W;
    c_val    = b_cal ? c_cal : c_nom;
    out_mv_d = b_err ? '0 : OUT_W'(c_val);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_mv    <= '0;
    end else begin
      out_valid <= b_vld;
      out_err   <= b_vld & b_err;
      if (b_vld) out_mv <= out_mv_d;
    end
  end

endmodule

// File: rtl/mvs_checker.sv
module mvs_checker #(
  parameter int OUT_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [4:0]              in_chan,
  input logic                    out_valid,
  input logic                    out_err,
  input logic signed [OUT_W-1:0] out_mv
);

  // R2: one result pulse per accepted item, fixed latency
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid && in_ready, 3));

  // R1: ready never drops once raised
  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(in_ready));

  // R8: error only on a result strobe, and carries a zero value
  p_err_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_mv == '0));

  // R8: channel zero is reported as unknown
  p_chan0_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && in_ready && in_chan == 5'd0, 3)) |-> out_err);

  // R6: die temperature stays inside its nominal span
  p_die_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && in_ready && in_chan == 5'd13, 3))
      |-> (!out_err && out_mv >= 0 && out_mv <= 1350));

endmodule

bind mv_scaler mvs_checker #(.OUT_W(OUT_W)) u_mvs_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_chan(in_chan), .out_valid(out_valid), .out_err(out_err), .out_mv(out_mv)
);

// File: tb/tb_mv_scaler.sv
module tb_mv_scaler;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic               in_ready;
  logic [4:0]         in_chan;
  logic [9:0]         in_code;
  logic [19:0]        gain_main, gain_temp, gain_vbat;
  logic signed [31:0] ofs_main, ofs_temp, ofs_vbat;
  logic               out_valid, out_err;
  logic signed [31:0] out_mv;

  always #4 clk = ~clk;

  mv_scaler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_code(in_code),
    .gain_main(gain_main), .ofs_main(ofs_main),
    .gain_temp(gain_temp), .ofs_temp(ofs_temp),
    .gain_vbat(gain_vbat), .ofs_vbat(ofs_vbat),
    .out_valid(out_valid), .out_err(out_err), .out_mv(out_mv)
  );

  typedef struct {
    bit     err;
    longint mv;
    int     due;
    string  tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  bit    mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint nominal(int lo, int hi, int code);
    return longint'(lo) + (longint'(hi - lo) * code) / 1024;
  endfunction

  function automatic longint calib(int code, logic [19:0] g, logic signed [31:0] o);
    return (longint'(code) * longint'(g) + longint'(o)) / 1000;
  endfunction

  // model from R3..R8
  function automatic void model(int ch, int code, output bit err, output longint mv);
    err = 1'b0;
    mv  = 0;
    case (ch)
      3:             mv = (gain_main != 0) ? calib(code, gain_main, ofs_main) : nominal(0, 20030, code);
      1, 2, 4, 6, 7: mv = (gain_temp != 0) ? calib(code, gain_temp, ofs_temp) : nominal(0, 1350, code);
      8:             mv = (gain_vbat != 0) ? calib(code, gain_vbat, ofs_vbat) : nominal(2300, 4800, code);
      5:             mv = nominal(0, 2500, code);
      9:             mv = nominal(0, 20030, code);
      10, 11:        mv = nominal(0, 1500, code);
      12:            mv = nominal(0, 3200, code);
      13:            mv = nominal(0, 1350, code);
      default:       err = 1'b1;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(int ch, int code, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_chan  = 5'(ch);
    in_code  = 10'(code);
    model(ch, code, it.err, it.mv);
    it.due = cyc + 3;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected result", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(cyc == it.due, "R2", "result cycle", cyc, it.due);
          check(out_err == it.err, it.tag, "error flag", out_err, it.err);
          check(longint'(out_mv) == (it.err ? 0 : it.mv), it.tag, "value",
                longint'(out_mv), it.err ? 0 : it.mv);
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        check(1'b0, "R2", "missing result", cyc, it.due);
      end
    end
  end

  task automatic set_ideal();
    gain_main = 20'd19556; ofs_main = 32'sd2668;
    gain_temp = 20'd1319;  ofs_temp = 32'sd785;
    gain_vbat = 20'd2444;  ofs_vbat = 32'sd2299992;
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R2", "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_chan  = '0;
    in_code  = '0;
    set_ideal();
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(out_err == 1'b0, "R1", "out_err in reset", out_err, 0);
    check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after release", in_ready, 1);
    mon_on = 1'b1;

    // R3, R4, R6, R7: every known channel at both end codes and a middle code
    for (int ch = 1; ch <= 13; ch++) begin
      send(ch, 0, "R3");
      send(ch, 1023, "R4");
      send(ch, 700, "R7");
    end
    idle(6);

    // R8: unknown channel numbers interleaved with known ones
    send(0, 55, "R8");
    send(13, 512, "R6");
    send(14, 3, "R8");
    send(8, 33, "R4");
    send(31, 1023, "R8");
    send(20, 0, "R8");
    idle(6);

    // R4: negative calibrated sums truncate toward zero
    ofs_temp = -32'sd500000;
    send(2, 0, "R4");
    send(2, 1, "R4");
    send(1, 379, "R4");
    send(7, 1023, "R4");
    idle(6);
    set_ideal();

    // R5, R9: main group uncalibrated, others keep calibration
    gain_main = '0;
    send(3, 1023, "R5");
    send(3, 16, "R5");
    send(8, 982, "R9");
    send(4, 985, "R9");
    idle(6);

    // R5, R6: all groups uncalibrated
    gain_temp = '0;
    gain_vbat = '0;
    send(8, 0, "R5");
    send(8, 1023, "R5");
    send(6, 512, "R5");
    send(10, 1023, "R6");
    idle(6);

    // random traffic, coefficients refreshed between bursts
    for (int b = 0; b < 20; b++) begin
      gain_main = ($urandom_range(0, 3) == 0) ? '0 : 20'($urandom);
      gain_temp = ($urandom_range(0, 3) == 0) ? '0 : 20'($urandom);
      gain_vbat = ($urandom_range(0, 3) == 0) ? '0 : 20'($urandom);
      ofs_main  = $signed($urandom);
      ofs_temp  = $signed($urandom);
      ofs_vbat  = $signed($urandom);
      for (int k = 0; k < 12; k++) begin
        send($urandom_range(0, 15), $urandom_range(0, 1023), "R9");
        if ($urandom_range(0, 2) == 0) idle(1);
      end
      idle(6);
    end

    idle(4);
    check(q.size() == 0, "R2", "outstanding results", q.size(), 0);
    check(in_ready == 1'b1, "R1", "in_ready held", in_ready, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule